// File: doc/BRIEF.md
# Write-Allocate Miss Fill Tracker

This block tracks cacheable store misses in a data cache that allocates on writes. A store that misses a line with no read already in flight claims one of a small set of fill entries, and the block issues a read for the full 32-byte line (eight 32-bit words) on an external request channel. A store that misses a line whose read is already in flight does not issue a second read. It is parked in a separate pending queue tagged with the fill it depends on.

Returning words carry the fill tag and their word offset, and they may arrive in any order. Each fill entry keeps a received-word mask. Once all eight words are present, the entry overlays the store that opened it. It then replays its pending stores one per cycle, oldest first, and offers the finished line to the cache array on a valid/ready write channel. The core is stalled whenever every fill entry is busy or the pending queue is full.

Victim selection, victim write-back and the tag array sit outside this block. They are represented only by the write channel's ready signal.

Top module: `wa_miss_tracker`

## Requirements
- R1: After reset `stall`, `rd_req_valid` and `wr_valid` are all low.
- R2: A store accepted while no fill for its line address is requesting, collecting or replaying claims a free fill entry, and exactly one read request carrying that line address is raised. While `rd_req_ready` is low, the request holds its line address and tag stable.
- R3: A store accepted while a fill for the same line address is requesting, collecting or replaying is queued as pending for that fill, and no further read request is raised.
- R4: `stall` is high whenever all FILL_N fill entries are busy or the pending queue holds PEND_N stores. A store presented while `stall` is high is not taken and produces no request and no line change.
- R5: Fill words are accepted when `rd_data_ready` is high. That happens only when `rd_data_id` names a fill that is collecting words. Words may arrive in any order, and word offset k lands in bits [32k+31:32k] of the line. A line is never offered before all eight offsets have been received.
- R6: The offered line equals the returned words with the opening store's bytes overlaid where its byte enables are set. Enable bit b replaces bits [8b+7:8b] of the addressed word.
- R7: Pending stores are applied after the opening store, in the order they were accepted, so a later store's enabled bytes win over an earlier one's.
- R8: `wr_valid` stays high with `wr_line` and `wr_data` unchanged until `wr_ready` is high. The entry is then freed.
- R9: Two fills proceed independently. Words returned for one tag never alter the other line, and a line that completes first is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store miss presented |
| st_line | input | 27 | Line address of the store |
| st_off | input | 3 | Word offset within the line |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables of the store |
| stall | output | 1 | Core must hold the store; a buffer is full |
| rd_req_valid | output | 1 | Line read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_line | output | 27 | Line address to read |
| rd_req_id | output | 1 | Fill tag of the request |
| rd_data_valid | input | 1 | Returned word valid |
| rd_data_ready | output | 1 | Block accepts the returned word |
| rd_data_id | input | 1 | Fill tag of the returned word |
| rd_data_off | input | 3 | Word offset of the returned word |
| rd_data | input | 32 | Returned word |
| wr_valid | output | 1 | Finished line offered to the cache |
| wr_ready | input | 1 | Cache array takes the line |
| wr_line | output | 27 | Line address of the finished line |
| wr_data | output | 256 | Finished line, word k at bits [32k+31:32k] |

## Verification
The bench returns words in forward, reversed and odd-stride orders, and checks that no line appears before the last word arrives. A design that completed on a word count, or on the highest offset, would offer a line with a hole in it. Several stores to one in-flight line with overlapping byte enables check the replay order. Replaying them out of order, or dropping the opening store, leaves the wrong byte in the shared word. The bench also fills the pending queue, presents a store while stalled, and interleaves words for two tags. A design that leaked a stalled store would raise an extra read, and one that mixed up tags would corrupt the other line or offer it too early.

// File: rtl/wa_fill_pkg.sv
package wa_fill_pkg;
    parameter int WORD_W      = 32;
    parameter int LINE_WORDS  = 8;
    parameter int LINE_ADDR_W = 27;
    localparam int BYTES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int LINE_W = WORD_W * LINE_WORDS;

    typedef enum logic [2:0] {
        F_FREE  = 3'd0,
        F_REQ   = 3'd1,
        F_WAIT  = 3'd2,
        F_MERGE = 3'd3,
        F_OUT   = 3'd4
    } fstate_e;

    typedef struct packed {
        fstate_e                st;
        logic [LINE_ADDR_W-1:0] line;
        logic [LINE_WORDS-1:0]  got;
        logic [LINE_W-1:0]      data;
        logic [OFF_W-1:0]       s_off;
        logic [WORD_W-1:0]      s_data;
        logic [BYTES-1:0]       s_be;
    } fill_t;
endpackage

// File: rtl/wa_first_set.sv
module wa_first_set #(
    parameter int N     = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wa_line_match.sv
module wa_line_match #(
    parameter int N  = 2,
    parameter int AW = 27
) (
    input  logic [N-1:0]         elig,
    input  logic [N-1:0][AW-1:0] lines,
    input  logic [AW-1:0]        probe,
    output logic [N-1:0]         hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = elig[g] && (lines[g] == probe);
    end
endmodule

// File: rtl/wa_line_merge.sv
module wa_line_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int BYTES  = WORD_W / 8,
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = WORD_W * LINE_WORDS
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BYTES-1:0]  be,
    output logic [LINE_W-1:0] line_o
);
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign line_o[w*WORD_W + b*8 +: 8] =
                ((off == OFF_W'(w)) && be[b]) ? wdata[b*8 +: 8]
                                              : line_i[w*WORD_W + b*8 +: 8];
        end
    end
endmodule

// File: rtl/wa_miss_tracker.sv
module wa_miss_tracker
    import wa_fill_pkg::*;
#(
    parameter int FILL_N = 2,
    parameter int PEND_N = 4,
    localparam int FID_W  = (FILL_N > 1) ? $clog2(FILL_N) : 1,
    localparam int PIDX_W = (PEND_N > 1) ? $clog2(PEND_N) : 1,
    localparam int PCNT_W = $clog2(PEND_N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    input  logic [LINE_ADDR_W-1:0] st_line,
    input  logic [OFF_W-1:0]       st_off,
    input  logic [WORD_W-1:0]      st_data,
    input  logic [BYTES-1:0]       st_be,
    output logic                   stall,
    output logic                   rd_req_valid,
    input  logic                   rd_req_ready,
    output logic [LINE_ADDR_W-1:0] rd_req_line,
    output logic [FID_W-1:0]       rd_req_id,
    input  logic                   rd_data_valid,
    output logic                   rd_data_ready,
    input  logic [FID_W-1:0]       rd_data_id,
    input  logic [OFF_W-1:0]       rd_data_off,
    input  logic [WORD_W-1:0]      rd_data,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [LINE_ADDR_W-1:0] wr_line,
    output logic [LINE_W-1:0]      wr_data
);
    typedef struct packed {
        logic              vld;
        logic [FID_W-1:0]  fid;
        logic [OFF_W-1:0]  off;
        logic [WORD_W-1:0] data;
        logic [BYTES-1:0]  be;
    } pend_t;

    typedef struct packed {
        fill_t [FILL_N-1:0] fill;
        pend_t [PEND_N-1:0] pend;
        logic [PCNT_W-1:0]  pcnt;
        logic               rq_hold;
        logic [FID_W-1:0]   rq_id;
        logic               wr_hold;
        logic [FID_W-1:0]   wr_id;
    } state_t;

    state_t state_d, state_q;

    // per-fill status vectors
    logic [FILL_N-1:0]                  busy_vec, free_vec, elig_vec;
    logic [FILL_N-1:0]                  req_vec, out_vec, merge_vec;
    logic [FILL_N-1:0]                  hit_vec, pend_has, drain_vec;
    logic [FILL_N-1:0][LINE_ADDR_W-1:0] fill_lines;
    logic [PEND_N-1:0]                  pmatch;

    for (genvar f = 0; f < FILL_N; f++) begin : g_fill
        assign busy_vec[f]   = state_q.fill[f].st != F_FREE;
        assign free_vec[f]   = !busy_vec[f];
        assign req_vec[f]    = state_q.fill[f].st == F_REQ;
        assign merge_vec[f]  = state_q.fill[f].st == F_MERGE;
        assign out_vec[f]    = state_q.fill[f].st == F_OUT;
        assign elig_vec[f]   = req_vec[f] || merge_vec[f] ||
                               (state_q.fill[f].st == F_WAIT);
        assign fill_lines[f] = state_q.fill[f].line;
    end

    always_comb begin
        pend_has = '0;
        for (int p = 0; p < PEND_N; p++) begin
            for (int f = 0; f < FILL_N; f++) begin
                if (state_q.pend[p].vld && (32'(state_q.pend[p].fid) == f)) begin
                    pend_has[f] = 1'b1;
                end
            end
        end
    end

    assign drain_vec = merge_vec & pend_has;

    // line lookup and entry selection
    logic             hit_any, free_any, req_any, out_any, drain_any, pick_any;
    logic [FID_W-1:0] hit_id, free_id, req_low, out_low, drain_f;
    logic [PIDX_W-1:0] drain_p;

    wa_line_match #(.N(FILL_N), .AW(LINE_ADDR_W)) u_match (
        .elig(elig_vec), .lines(fill_lines), .probe(st_line), .hit(hit_vec)
    );
    wa_first_set #(.N(FILL_N)) u_pick_hit   (.req(hit_vec),   .found(hit_any),   .idx(hit_id));
    wa_first_set #(.N(FILL_N)) u_pick_free  (.req(free_vec),  .found(free_any),  .idx(free_id));
    wa_first_set #(.N(FILL_N)) u_pick_req   (.req(req_vec),   .found(req_any),   .idx(req_low));
    wa_first_set #(.N(FILL_N)) u_pick_out   (.req(out_vec),   .found(out_any),   .idx(out_low));
    wa_first_set #(.N(FILL_N)) u_pick_drain (.req(drain_vec), .found(drain_any), .idx(drain_f));

    for (genvar p = 0; p < PEND_N; p++) begin : g_pend
        assign pmatch[p] = state_q.pend[p].vld && (state_q.pend[p].fid == drain_f);
    end
    wa_first_set #(.N(PEND_N)) u_pick_pend (.req(pmatch), .found(pick_any), .idx(drain_p));

    // line assembly paths
    logic [LINE_W-1:0] word_line, done_line, drained_line;

    wa_line_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_put_word (
        .line_i(state_q.fill[rd_data_id].data), .off(rd_data_off),
        .wdata(rd_data), .be({BYTES{1'b1}}), .line_o(word_line)
    );
    wa_line_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_put_store (
        .line_i(word_line), .off(state_q.fill[rd_data_id].s_off),
        .wdata(state_q.fill[rd_data_id].s_data), .be(state_q.fill[rd_data_id].s_be),
        .line_o(done_line)
    );
    wa_line_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_put_pend (
        .line_i(state_q.fill[drain_f].data), .off(state_q.pend[drain_p].off),
        .wdata(state_q.pend[drain_p].data), .be(state_q.pend[drain_p].be),
        .line_o(drained_line)
    );

    // next-state computation
    logic                  take, id_ok, drain_go;
    logic [FID_W-1:0]      req_id, wr_sel;
    logic [LINE_WORDS-1:0] got_n;
    pend_t [PEND_N-1:0]    pq;
    logic [PCNT_W-1:0]     cnt;

    always_comb begin
        state_d = state_q;

        stall = (&busy_vec) || (state_q.pcnt == PCNT_W'(PEND_N));
        take  = st_valid && !stall;

        // read request channel, held on a stalled handshake
        req_id          = state_q.rq_hold ? state_q.rq_id : req_low;
        rd_req_valid    = req_any;
        rd_req_id       = req_id;
        rd_req_line     = state_q.fill[req_id].line;
        state_d.rq_hold = rd_req_valid && !rd_req_ready;
        state_d.rq_id   = req_id;
        if (rd_req_valid && rd_req_ready) begin
            state_d.fill[req_id].st = F_WAIT;
        end

        // returned words, any order
        id_ok         = 32'(rd_data_id) < FILL_N;
        rd_data_ready = id_ok && (state_q.fill[rd_data_id].st == F_WAIT);
        got_n         = state_q.fill[rd_data_id].got | (LINE_WORDS'(1) << rd_data_off);
        if (rd_data_valid && rd_data_ready) begin
            state_d.fill[rd_data_id].got  = got_n;
            state_d.fill[rd_data_id].data = word_line;
            if (&got_n) begin
                state_d.fill[rd_data_id].data = done_line;
                state_d.fill[rd_data_id].st   = F_MERGE;
            end
        end

        // replay one pending store per cycle
        drain_go = drain_any && pick_any;
        if (drain_go) begin
            state_d.fill[drain_f].data = drained_line;
        end
        for (int f = 0; f < FILL_N; f++) begin
            if (merge_vec[f] && !pend_has[f] &&
                !(take && hit_any && (32'(hit_id) == f))) begin
                state_d.fill[f].st = F_OUT;
            end
        end

        // pending queue: remove replayed entry, keep order, append at tail
        for (int p = 0; p < PEND_N; p++) begin
            if (drain_go && (p >= 32'(drain_p))) begin
                pq[p] = (p + 1 < PEND_N) ? state_q.pend[(p + 1) % PEND_N] : '0;
            end else begin
                pq[p] = state_q.pend[p];
            end
        end
        cnt = state_q.pcnt - PCNT_W'(drain_go);
        if (take && hit_any && (32'(cnt) < PEND_N)) begin
            pq[cnt[PIDX_W-1:0]].vld  = 1'b1;
            pq[cnt[PIDX_W-1:0]].fid  = hit_id;
            pq[cnt[PIDX_W-1:0]].off  = st_off;
            pq[cnt[PIDX_W-1:0]].data = st_data;
            pq[cnt[PIDX_W-1:0]].be   = st_be;
            cnt = cnt + PCNT_W'(1);
        end
        state_d.pend = pq;
        state_d.pcnt = cnt;

        // new fill for a line with nothing in flight
        if (take && !hit_any && free_any) begin
            state_d.fill[free_id].st     = F_REQ;
            state_d.fill[free_id].line   = st_line;
            state_d.fill[free_id].got    = '0;
            state_d.fill[free_id].data   = '0;
            state_d.fill[free_id].s_off  = st_off;
            state_d.fill[free_id].s_data = st_data;
            state_d.fill[free_id].s_be   = st_be;
        end

        // finished line to the cache array, held on a stalled handshake
        wr_sel          = state_q.wr_hold ? state_q.wr_id : out_low;
        wr_valid        = out_any;
        wr_line         = state_q.fill[wr_sel].line;
        wr_data         = state_q.fill[wr_sel].data;
        state_d.wr_hold = wr_valid && !wr_ready;
        state_d.wr_id   = wr_sel;
        if (wr_valid && wr_ready) begin
            state_d.fill[wr_sel].st = F_FREE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wa_miss_tracker_chk.sv
module wa_miss_tracker_chk
    import wa_fill_pkg::*;
#(
    parameter int FILL_N = 2,
    localparam int FID_W = (FILL_N > 1) ? $clog2(FILL_N) : 1,
    localparam int CNT_W = $clog2(FILL_N + 1) + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_req_valid,
    input logic                   rd_req_ready,
    input logic [LINE_ADDR_W-1:0] rd_req_line,
    input logic [FID_W-1:0]       rd_req_id,
    input logic                   rd_data_ready,
    input logic                   wr_valid,
    input logic                   wr_ready,
    input logic [LINE_ADDR_W-1:0] wr_line,
    input logic [LINE_W-1:0]      wr_data
);
    logic [CNT_W-1:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CNT_W'(rd_req_valid && rd_req_ready)
                                 - CNT_W'(wr_valid && wr_ready);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_line) && $stable(rd_req_id)); // R2
    AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(FILL_N)); // R4
    AST_DATA_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_ready |-> inflight != '0); // R5
    AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> inflight != '0); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_line) && $stable(wr_data)); // R8
endmodule

bind wa_miss_tracker wa_miss_tracker_chk #(.FILL_N(FILL_N)) u_chk (.*);

// File: tb/wa_miss_tracker_bench.sv
module wa_miss_tracker_bench;
    import wa_fill_pkg::*;
    localparam int FILL_N = 2;
    localparam int PEND_N = 4;
    localparam int FID_W  = 1;

    logic                   clk, rst_n;
    logic                   st_valid, stall;
    logic [LINE_ADDR_W-1:0] st_line;
    logic [OFF_W-1:0]       st_off;
    logic [WORD_W-1:0]      st_data;
    logic [BYTES-1:0]       st_be;
    logic                   rd_req_valid, rd_req_ready;
    logic [LINE_ADDR_W-1:0] rd_req_line;
    logic [FID_W-1:0]       rd_req_id;
    logic                   rd_data_valid, rd_data_ready;
    logic [FID_W-1:0]       rd_data_id;
    logic [OFF_W-1:0]       rd_data_off;
    logic [WORD_W-1:0]      rd_data;
    logic                   wr_valid, wr_ready;
    logic [LINE_ADDR_W-1:0] wr_line;
    logic [LINE_W-1:0]      wr_data;

    wa_miss_tracker #(.FILL_N(FILL_N), .PEND_N(PEND_N)) u_wa_miss_tracker (.*);

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] base_line(input logic [WORD_W-1:0] base);
        logic [LINE_W-1:0] r;
        for (int k = 0; k < LINE_WORDS; k++) r[k*WORD_W +: WORD_W] = base + WORD_W'(k);
        return r;
    endfunction

    task automatic do_store(input logic [LINE_ADDR_W-1:0] l, input logic [OFF_W-1:0] o,
                            input logic [WORD_W-1:0] d, input logic [BYTES-1:0] be);
        int n = 0;
        @(negedge clk);
        while (stall && n < 50) begin @(negedge clk); n++; end
        st_valid = 1'b1; st_line = l; st_off = o; st_data = d; st_be = be;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic get_req(input logic [LINE_ADDR_W-1:0] l, output logic [FID_W-1:0] id);
        int n = 0;
        while (!rd_req_valid && n < 50) begin @(negedge clk); n++; end
        chk(rd_req_valid && rd_req_line == l, "R2 request line",
            LINE_W'({rd_req_valid, rd_req_line}), LINE_W'({1'b1, l}));
        id = rd_req_id;
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
    endtask

    task automatic send_word(input logic [FID_W-1:0] id, input logic [OFF_W-1:0] o,
                             input logic [WORD_W-1:0] d);
        rd_data_valid = 1'b1; rd_data_id = id; rd_data_off = o; rd_data = d;
        #1;
        chk(rd_data_ready, "R5 word accepted", LINE_W'(rd_data_ready), LINE_W'(1));
        @(negedge clk);
        rd_data_valid = 1'b0;
    endtask

    task automatic wait_wr();
        int n = 0;
        while (!wr_valid && n < 50) begin @(negedge clk); n++; end
    endtask

    task automatic get_wr(output logic [LINE_ADDR_W-1:0] l, output logic [LINE_W-1:0] d);
        wait_wr();
        chk(wr_valid, "R5 line offered", LINE_W'(wr_valid), LINE_W'(1));
        l = wr_line; d = wr_data;
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [LINE_ADDR_W-1:0] line;
        logic [OFF_W-1:0]       off;
        logic [WORD_W-1:0]      data;
        logic [BYTES-1:0]       be;
        logic [2:0]             start;
        logic [2:0]             stride;
        logic [WORD_W-1:0]      exp;
    } vec_t;

    // fill word k is 32'h5A5A5A00 + k; exp is the merged word at the store offset (R6)
    localparam vec_t VECS [4] = '{
        '{27'h100, 3'd0, 32'h11223344, 4'b1111, 3'd0, 3'd1, 32'h11223344},
        '{27'h101, 3'd7, 32'hAABBCCDD, 4'b0001, 3'd7, 3'd7, 32'h5A5A5ADD},
        '{27'h2A2, 3'd3, 32'hDEADBEEF, 4'b1010, 3'd5, 3'd3, 32'hDE5ABE03},
        '{27'h3FF, 3'd4, 32'h01020304, 4'b0000, 3'd2, 3'd5, 32'h5A5A5A04}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [FID_W-1:0]       id, idx, idy;
        logic [LINE_ADDR_W-1:0] l, l0;
        logic [LINE_W-1:0]      d, e, d0;

        rst_n = 1'b0; st_valid = 1'b0; st_line = '0; st_off = '0; st_data = '0; st_be = '0;
        rd_req_ready = 1'b0; rd_data_valid = 1'b0; rd_data_id = '0; rd_data_off = '0;
        rd_data = '0; wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!stall && !rd_req_valid && !wr_valid, "R1 idle after reset",
            LINE_W'({stall, rd_req_valid, wr_valid}), '0);

        // vector table: one store per line, varied word orders and byte enables
        for (int v = 0; v < 4; v++) begin
            do_store(VECS[v].line, VECS[v].off, VECS[v].data, VECS[v].be);
            get_req(VECS[v].line, id);
            for (int j = 0; j < LINE_WORDS; j++) begin
                logic [OFF_W-1:0] k;
                k = OFF_W'(VECS[v].start + OFF_W'(j) * VECS[v].stride);
                if (j == LINE_WORDS - 1)
                    chk(!wr_valid, "R5 no line before last word", LINE_W'(wr_valid), '0);
                send_word(id, k, 32'h5A5A5A00 + WORD_W'(k));
            end
            get_wr(l, d);
            e = base_line(32'h5A5A5A00);
            e[VECS[v].off*WORD_W +: WORD_W] = VECS[v].exp;
            chk(d == e && l == VECS[v].line, "R6 merged line", d, e);
        end

        // pending stores on one in-flight line, replay order and queue-full stall
        do_store(27'h55, 3'd2, 32'h000000AA, 4'b0001);
        get_req(27'h55, id);
        do_store(27'h55, 3'd2, 32'h0000BBCC, 4'b0011);
        do_store(27'h55, 3'd2, 32'h000000DD, 4'b0001);
        do_store(27'h55, 3'd2, 32'h11000000, 4'b1000);
        chk(!stall, "R4 three pending no stall", LINE_W'(stall), '0);
        chk(!rd_req_valid, "R3 no second read", LINE_W'(rd_req_valid), '0);
        do_store(27'h55, 3'd5, 32'h77777777, 4'b1111);
        chk(stall, "R4 pending full stalls", LINE_W'(stall), LINE_W'(1));
        st_valid = 1'b1; st_line = 27'h77; st_off = '0; st_data = '1; st_be = '1;
        repeat (3) @(negedge clk);
        st_valid = 1'b0;
        chk(stall && !rd_req_valid, "R4 stalled store not taken",
            LINE_W'({stall, rd_req_valid}), LINE_W'(2'b10));
        for (int k = LINE_WORDS - 1; k >= 0; k--) send_word(id, OFF_W'(k), 32'h5A5A5A00 + WORD_W'(k));
        get_wr(l, d);
        e = base_line(32'h5A5A5A00);
        e[2*WORD_W +: WORD_W] = 32'h115ABBDD;
        e[5*WORD_W +: WORD_W] = 32'h77777777;
        chk(d == e && l == 27'h55, "R7 pending replay order", d, e);
        chk(!stall, "R4 stall released", LINE_W'(stall), '0);
        repeat (5) @(negedge clk);
        chk(!rd_req_valid, "R4 dropped store raised no read", LINE_W'(rd_req_valid), '0);

        // two fills at once, request hold, interleaved words, write hold
        do_store(27'h10, 3'd0, 32'h0, 4'b0000);
        do_store(27'h20, 3'd1, 32'h0, 4'b0000);
        chk(stall, "R4 all fills busy", LINE_W'(stall), LINE_W'(1));
        rd_data_id = '0;
        #1;
        chk(!rd_data_ready, "R5 not ready before request", LINE_W'(rd_data_ready), '0);
        l0 = rd_req_line;
        repeat (3) @(negedge clk);
        chk(rd_req_valid && rd_req_line == l0, "R2 request held", LINE_W'(rd_req_line), LINE_W'(l0));
        get_req(27'h10, idx);
        get_req(27'h20, idy);
        for (int k = 0; k < LINE_WORDS; k++) begin
            send_word(idy, OFF_W'(k), 32'hC3C3C300 + WORD_W'(k));
            if (k < LINE_WORDS - 1)
                send_word(idx, OFF_W'(7 - k), 32'h5A5A5A00 + WORD_W'(7 - k));
        end
        wait_wr();
        d0 = wr_data;
        repeat (3) @(negedge clk);
        chk(wr_valid && wr_data == d0, "R8 line held until ready", wr_data, d0);
        get_wr(l, d);
        chk(l == 27'h20 && d == base_line(32'hC3C3C300), "R9 first finished line", d,
            base_line(32'hC3C3C300));
        send_word(idx, 3'd0, 32'h5A5A5A00);
        get_wr(l, d);
        chk(l == 27'h10 && d == base_line(32'h5A5A5A00), "R9 second line intact", d,
            base_line(32'h5A5A5A00));
        chk(!wr_valid, "R8 entry freed", LINE_W'(wr_valid), '0);
        rd_data_id = idx;
        #1;
        chk(!rd_data_ready, "R5 freed tag not ready", LINE_W'(rd_data_ready), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule